// File: doc/BRIEF.md
# Latched Analog Multiplexer Channel Controller

This block is the digital control for a bank of analog switches whose channel choice is written over a processor bus. A channel address and an enable bit are taken into holding registers under an active-low write strobe. While the strobe is low the registers follow the bus. While it is high they keep what they last took. The held state is decoded into one-hot switch-drive vectors. An asynchronous master reset, active low, clears the holding registers and turns every switch off, whatever the other inputs are doing.

A static mode input picks one of two arrangements. In the first, eight single-ended channels are selected by three address bits. In the second, four differential pairs are selected by the two low address bits, and each pair drives a matched "a" and "b" switch. Whenever the selection moves to a newly enabled channel, the outputs pass through an all-off interval of `GAP_CYCLES` clock cycles first, so two inputs are never joined. Turning the switches off needs no such interval.

Top module: `amux_chan_ctrl`

## Requirements
- R1: While `wrN` is low, the address and enable on the bus are loaded into the holding registers on every clock edge. The selection they describe reaches the outputs without any further write.
- R2: The holding registers keep the values taken at the last clock edge on which `wrN` was low. Changes on `addr` and `enIn` while `wrN` is high leave the outputs unchanged.
- R3: A held enable of 0 forces `swA` and `swB` to all zero whatever the held address. The outputs go off on the clock edge that follows the edge on which the enable of 0 was loaded, with no gap.
- R4: While `rstN` is low, `swA` and `swB` are zero at once, with no clock edge needed, regardless of `wrN`, `addr` and `enIn`.
- R5: After `rstN` is released, all outputs stay zero until a write loads an enable of 1.
- R6: With `diffMode` = 0 and a held enable of 1, an address value k (0 to 7) drives `swA` to a single 1 at bit k, which is switch k+1, and `swB` to zero.
- R7: With `diffMode` = 1 and a held enable of 1, `addr[1:0]` = k (0 to 3) sets bit k of both `swA` and `swB`. `swA[7:4]` stays zero, and `addr[2]` has no effect: two addresses that differ only in that bit give the same selection and no gap.
- R8: At most one bit of `swA` and at most one bit of `swB` are ever 1. The outputs never move directly from one non-zero pattern to a different non-zero pattern.
- R9: When the held selection changes to a newly enabled channel, the outputs are zero for exactly `GAP_CYCLES` cycles. Counting from the edge that loads the new value, the new channel appears after edge `GAP_CYCLES`+1.
- R10: A change of selection that arrives while a gap is running restarts the gap for the newest selection. A selection that was replaced during its gap never appears.
- R11: Reloading the selection that is already on causes no gap and no change at the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Master reset, active low, asynchronous; clears the held state and the outputs |
| wrN | input | 1 | Write strobe, active low; the holding registers load while it is low |
| addr | input | 3 | Channel address; only bits 1:0 are used in differential mode |
| enIn | input | 1 | Enable bit, stored with the address |
| diffMode | input | 1 | Static mode: 0 for eight single-ended channels, 1 for four differential pairs |
| swA | output | 8 | Switch drives: single-ended switches 1..8, or the "a" switches of pairs 1..4 on bits 3:0 |
| swB | output | 4 | Switch drives for the "b" switches of pairs 1..4; zero in single-ended mode |

## Verification
The tests sweep all eight single-ended addresses and all four pairs. Each one is checked during its gap cycles and in the cycle it turns on, which separates correct decoding and gap length from off-by-one timing. A stream of new addresses with the strobe held low tells transparent loading and gap restart apart from a design that keeps only the first value or lets an interrupted channel through. Bus activity with the strobe high, rewrites of the live channel, addresses that differ only in the unused bit, a write with the enable cleared, and a reset raised between clock edges show which inputs must have no effect and which effects must be immediate.

// File: rtl/amux_pkg.sv
package amux_pkg;

  // Width of the channel address; the single-ended channel count is 2**ADDR_W.
  localparam int unsigned ADDR_W = 3;

  // One selection: whether anything is on, which mode it was decoded in,
  // and the channel or pair index.
  typedef struct packed {
    logic              valid;
    logic              diff;
    logic [ADDR_W-1:0] idx;
  } selKey_t;

  localparam selKey_t KEY_OFF = '0;

  // Strobes from the break-before-make sequencer to the datapath.
  typedef struct packed {
    logic clearOut;   // drive the output selection to off
    logic loadOut;    // put the current target on the outputs
    logic clearPend;  // forget the selection waiting for its gap
    logic latchPend;  // remember the current target as the waiting one
  } bbmStrobe_t;

endpackage

// File: rtl/amux_datapath.sv
module amux_datapath
  import amux_pkg::*;
#(
  parameter int unsigned NUM_SE   = 8,
  parameter int unsigned NUM_PAIR = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrN,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                enIn,
  input  logic                diffMode,
  input  bbmStrobe_t          strobe,
  output logic                tgtValid,
  output logic                tgtMatchesOut,
  output logic                tgtMatchesPend,
  output logic [NUM_SE-1:0]   swA,
  output logic [NUM_PAIR-1:0] swB
);

  logic [ADDR_W-1:0] heldAddr;
  logic              heldEn;
  selKey_t           tgtKey;
  selKey_t           outKey;
  selKey_t           pendKey;

  // Holding registers: follow the bus while the strobe is low.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldAddr <= '0;
      heldEn   <= 1'b0;
    end else if (!wrN) begin
      heldAddr <= addr;
      heldEn   <= enIn;
    end
  end

  // Target selection from the held state; the top address bit is dropped
  // in differential mode.
  always_comb begin
    tgtKey = KEY_OFF;
    if (heldEn) begin
      tgtKey.valid = 1'b1;
      tgtKey.diff  = diffMode;
      if (diffMode) begin
        tgtKey.idx = {1'b0, heldAddr[ADDR_W-2:0]};
      end else begin
        tgtKey.idx = heldAddr;
      end
    end
  end

  assign tgtValid       = tgtKey.valid;
  assign tgtMatchesOut  = (tgtKey == outKey);
  assign tgtMatchesPend = (tgtKey == pendKey);

  // Selection now driven and selection waiting for its gap.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outKey  <= KEY_OFF;
      pendKey <= KEY_OFF;
    end else begin
      if (strobe.clearOut) begin
        outKey <= KEY_OFF;
      end else if (strobe.loadOut) begin
        outKey <= tgtKey;
      end
      if (strobe.clearPend) begin
        pendKey <= KEY_OFF;
      end else if (strobe.latchPend) begin
        pendKey <= tgtKey;
      end
    end
  end

  // One-hot switch drives.
  for (genvar i = 0; i < NUM_SE; i++) begin : g_drvA
    assign swA[i] = outKey.valid && (outKey.idx == ADDR_W'(i));
  end

  for (genvar j = 0; j < NUM_PAIR; j++) begin : g_drvB
    assign swB[j] = outKey.valid && outKey.diff && (outKey.idx == ADDR_W'(j));
  end

endmodule

// File: rtl/amux_bbm_ctrl.sv
module amux_bbm_ctrl
  import amux_pkg::*;
#(
  parameter int unsigned GAP_CYCLES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tgtValid,
  input  logic       tgtMatchesOut,
  input  logic       tgtMatchesPend,
  output bbmStrobe_t strobe
);

  localparam int unsigned CNT_W = $clog2(GAP_CYCLES + 1);
  localparam logic [CNT_W-1:0] GAP_LOAD = CNT_W'(GAP_CYCLES);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  if (GAP_CYCLES < 1) begin : g_badGap
    $error("GAP_CYCLES must be at least 1");
  end

  logic [CNT_W-1:0] gapCnt;
  logic [CNT_W-1:0] gapNext;

  always_comb begin
    strobe  = '0;
    gapNext = gapCnt;
    if (!tgtValid) begin
      // Turning off is immediate; no gap is needed.
      strobe.clearOut  = 1'b1;
      strobe.clearPend = 1'b1;
      gapNext          = '0;
    end else if (tgtMatchesOut) begin
      // Already showing the target.
      strobe.latchPend = 1'b1;
      gapNext          = '0;
    end else if (!tgtMatchesPend || gapCnt == '0) begin
      // New target: open the outputs and (re)start the gap.
      strobe.clearOut  = 1'b1;
      strobe.latchPend = 1'b1;
      gapNext          = GAP_LOAD;
    end else if (gapCnt == CNT_ONE) begin
      strobe.loadOut = 1'b1;
      gapNext        = '0;
    end else begin
      gapNext = gapCnt - CNT_ONE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gapCnt <= '0;
    end else begin
      gapCnt <= gapNext;
    end
  end

endmodule

// File: rtl/amux_chan_ctrl.sv
module amux_chan_ctrl
  import amux_pkg::*;
#(
  parameter int unsigned GAP_CYCLES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              enIn,
  input  logic              diffMode,
  output logic [(1<<ADDR_W)-1:0]     swA,
  output logic [(1<<(ADDR_W-1))-1:0] swB
);

  localparam int unsigned NUM_SE   = 1 << ADDR_W;
  localparam int unsigned NUM_PAIR = NUM_SE / 2;

  bbmStrobe_t strobe;
  logic       tgtValid;
  logic       tgtMatchesOut;
  logic       tgtMatchesPend;

  amux_datapath #(
    .NUM_SE  (NUM_SE),
    .NUM_PAIR(NUM_PAIR)
  ) uPath (
    .clk           (clk),
    .rstN          (rstN),
    .wrN           (wrN),
    .addr          (addr),
    .enIn          (enIn),
    .diffMode      (diffMode),
    .strobe        (strobe),
    .tgtValid      (tgtValid),
    .tgtMatchesOut (tgtMatchesOut),
    .tgtMatchesPend(tgtMatchesPend),
    .swA           (swA),
    .swB           (swB)
  );

  amux_bbm_ctrl #(
    .GAP_CYCLES(GAP_CYCLES)
  ) uCtrl (
    .clk           (clk),
    .rstN          (rstN),
    .tgtValid      (tgtValid),
    .tgtMatchesOut (tgtMatchesOut),
    .tgtMatchesPend(tgtMatchesPend),
    .strobe        (strobe)
  );

endmodule

// File: rtl/amux_chan_ctrl_chk.sv
module amux_chan_ctrl_chk #(
  parameter int unsigned GAP_CYCLES = 2,
  parameter int unsigned NUM_SE     = 8,
  parameter int unsigned NUM_PAIR   = 4
) (
  input logic                clk,
  input logic                rstN,
  input logic                wrN,
  input logic                enIn,
  input logic [NUM_SE-1:0]   swA,
  input logic [NUM_PAIR-1:0] swB
);

  localparam int unsigned OFF_W = $clog2(GAP_CYCLES + 2);
  localparam logic [OFF_W-1:0] OFF_SAT = OFF_W'(GAP_CYCLES);

  // Consecutive sampled all-off cycles, saturating at the gap length.
  logic [OFF_W-1:0] offCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      offCnt <= '0;
    end else if (swA == '0 && swB == '0) begin
      if (offCnt != OFF_SAT) offCnt <= offCnt + OFF_W'(1);
    end else begin
      offCnt <= '0;
    end
  end

  // R8: never more than one channel or pair on.
  assert_one_hot_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(swA) && $onehot0(swB));

  // R8: no direct jump from one live channel to another.
  assert_break_first_R8: assert property (@(posedge clk) disable iff (!rstN)
    ((|$past(swA)) && (|swA)) |-> (swA == $past(swA) && swB == $past(swB)));

  // R7: a live b switch always mirrors the a switch of the same pair.
  assert_pair_match_R7: assert property (@(posedge clk) disable iff (!rstN)
    (|swB) |-> (swA[NUM_PAIR-1:0] == swB && swA[NUM_SE-1:NUM_PAIR] == '0));

  // R9: a channel only turns on after at least GAP_CYCLES off cycles.
  assert_gap_length_R9: assert property (@(posedge clk) disable iff (!rstN)
    ((|swA) && !(|$past(swA))) |-> (offCnt >= OFF_SAT));

  // R3: an enable of 0 loaded two edges ago leaves everything off.
  assert_enable_off_R3: assert property (@(posedge clk) disable iff (!rstN)
    $past(!wrN && !enIn, 2) |-> (swA == '0 && swB == '0));

  // R4: outputs are cleared whenever the master reset is low.
  always @(negedge clk) begin
    if (rstN == 1'b0) begin
      assert_reset_clear_R4: assert (swA == '0 && swB == '0);
    end
  end

endmodule

bind amux_chan_ctrl amux_chan_ctrl_chk #(
  .GAP_CYCLES(GAP_CYCLES),
  .NUM_SE    (NUM_SE),
  .NUM_PAIR  (NUM_PAIR)
) uChk (
  .clk (clk),
  .rstN(rstN),
  .wrN (wrN),
  .enIn(enIn),
  .swA (swA),
  .swB (swB)
);

// File: tb/tb_amux_chan_ctrl.sv
module tb_amux_chan_ctrl;

  localparam int GAP = 2;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrN = 1'b1;
  logic [2:0] addr = '0;
  logic       enIn = 1'b0;
  logic       diffMode = 1'b0;
  logic [7:0] swA;
  logic [3:0] swB;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  amux_chan_ctrl #(.GAP_CYCLES(GAP)) dut (
    .clk     (clk),
    .rstN    (rstN),
    .wrN     (wrN),
    .addr    (addr),
    .enIn    (enIn),
    .diffMode(diffMode),
    .swA     (swA),
    .swB     (swB)
  );

  function automatic logic [7:0] seA(input logic [2:0] a);
    return 8'(1) << a;
  endfunction

  function automatic logic [7:0] dfA(input logic [2:0] a);
    return 8'(1) << a[1:0];
  endfunction

  function automatic logic [3:0] dfB(input logic [2:0] a);
    return 4'(1) << a[1:0];
  endfunction

  task automatic chk(input logic [7:0] expA, input logic [3:0] expB, input string tag);
    checks++;
    if (swA !== expA || swB !== expB) begin
      fails++;
      $display("FAIL %s: swA=%b swB=%b expected swA=%b swB=%b", tag, swA, swB, expA, expB);
    end
  endtask

  // Called at a falling edge; the capture happens at the next rising edge,
  // and the task returns at the falling edge after it.
  task automatic writeSel(input logic [2:0] a, input logic e);
    addr = a;
    enIn = e;
    wrN  = 1'b0;
    @(negedge clk);
    wrN  = 1'b1;
  endtask

  task automatic expectGapThenOn(input logic [7:0] expA, input logic [3:0] expB, input string tag);
    for (int k = 0; k < GAP; k++) begin
      @(negedge clk);
      chk(8'h00, 4'h0, {tag, " R9 gap"});
    end
    @(negedge clk);
    chk(expA, expB, {tag, " R9 on"});
  endtask

  task automatic testReset();
    wrN  = 1'b0;
    addr = 3'd5;
    enIn = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(8'h00, 4'h0, "R4 bus active during reset");
    end
    wrN = 1'b1;
    @(negedge clk);
    rstN = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(8'h00, 4'h0, "R5 off after release");
    end
  endtask

  task automatic testSeSweep();
    for (int a = 0; a < 8; a++) begin
      writeSel(3'(a), 1'b1);
      expectGapThenOn(seA(3'(a)), 4'h0, "R6 R1 single-ended sweep");
    end
  endtask

  task automatic testHold();
    addr = 3'd1;
    enIn = 1'b0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk(seA(3'd7), 4'h0, "R2 bus ignored while strobe high");
      addr = addr + 3'd1;
      enIn = ~enIn;
    end
  endtask

  task automatic testTransparent();
    logic [2:0] seq [4] = '{3'd3, 3'd4, 3'd5, 3'd6};
    wrN  = 1'b0;
    enIn = 1'b1;
    for (int k = 0; k < 4; k++) begin
      addr = seq[k];
      @(negedge clk);
      if (k > 0) chk(8'h00, 4'h0, "R10 R1 gap restarted while strobe low");
    end
    wrN = 1'b1;
    addr = 3'd0;
    expectGapThenOn(seA(3'd6), 4'h0, "R1 R2 last value kept");
  endtask

  task automatic testEnableOff();
    writeSel(3'd6, 1'b0);
    chk(seA(3'd6), 4'h0, "R3 still on one edge after load");
    @(negedge clk);
    chk(8'h00, 4'h0, "R3 off without gap");
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(8'h00, 4'h0, "R3 stays off");
    end
    writeSel(3'd6, 1'b1);
    expectGapThenOn(seA(3'd6), 4'h0, "R9 turn-on from off");
  endtask

  task automatic testSameRewrite();
    writeSel(3'd6, 1'b1);
    chk(seA(3'd6), 4'h0, "R11 rewrite same channel");
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(seA(3'd6), 4'h0, "R11 no gap on rewrite");
    end
  endtask

  task automatic testRestart();
    writeSel(3'd1, 1'b1);
    writeSel(3'd2, 1'b1);
    chk(8'h00, 4'h0, "R10 off during first gap");
    expectGapThenOn(seA(3'd2), 4'h0, "R10 replaced selection");
  endtask

  task automatic testAsyncReset();
    #2;
    rstN = 1'b0;
    #1;
    chk(8'h00, 4'h0, "R4 immediate clear between edges");
    wrN  = 1'b0;
    addr = 3'd4;
    enIn = 1'b1;
    @(negedge clk);
    chk(8'h00, 4'h0, "R4 reset overrides write");
    wrN = 1'b1;
    diffMode = 1'b1;
    @(negedge clk);
    rstN = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(8'h00, 4'h0, "R5 no channel until written");
    end
  endtask

  task automatic testDiff();
    writeSel(3'b110, 1'b1);
    expectGapThenOn(dfA(3'b110), dfB(3'b110), "R7 pair 3");
    writeSel(3'b010, 1'b1);
    chk(dfA(3'b010), dfB(3'b010), "R7 top address bit ignored");
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(dfA(3'b010), dfB(3'b010), "R7 no gap when only top bit differs");
    end
    for (int p = 0; p < 4; p++) begin
      logic [2:0] a;
      a = {1'b1, 2'(p)};
      writeSel(a, 1'b1);
      expectGapThenOn(dfA(a), dfB(a), "R7 pair sweep");
    end
  endtask

  initial begin
    @(negedge clk);
    testReset();
    testSeSweep();
    testHold();
    testTransparent();
    testEnableOff();
    testSameRewrite();
    testRestart();
    testAsyncReset();
    testDiff();
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog (R1..all): actual=still running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule